// File: doc/BRIEF.md
# Bus-Cycle Driven Serial Configuration Bridge

This block sits in the FPGA of a peripheral card on an 8-bit microcomputer expansion bus. It lets host software talk to a hard serial (SPI) configuration port one bit per bus access, with no shift register or SPI master inside the FPGA. Host software first writes an unlock value to a control strobe location. The bridge then pulls the open-drain chip-select low. On the board, the slot's active-low device-select strobe is wired to the SPI clock and bus address bit 0 is wired to the serial input. Each access to the card's 16-byte device region therefore sends one bit: an odd offset sends a 1 and an even offset sends a 0. The bit is taken when the strobe rises.

The serial reply pin is brought into the system clock through a synchronizer. While the serial path is enabled, a read of one of the two reply offsets returns the reply level on data bit 7 and zeros below it. The serial path counts as enabled when the bridge drives chip-select low, and also when a board jumper holds the chip-select pin low. Any other read passes the disk-controller register value through unchanged. The bridge also runs the external bus transceiver. It enables the transceiver for every device access and points it toward the bus only on reads.

Top module: `spi_bitbang_bridge`

## Requirements
- R1: While reset is high and on the first cycle after it, `cs_drive_low`, `xcvr_oe`, `xcvr_to_bus` are 0 and `bus_rdata` is 0x00.
- R2: When the serial path is not enabled, a read access of any offset, including 0xA and 0xB, returns `core_rdata` unchanged on `bus_rdata`.
- R3: A control write (falling `ctl_sel_n` with `bus_rd`=0) carrying the grant value 0xA5 sets `cs_drive_low` to 1.
- R4: When the serial path is enabled, a read of offset 0xA or 0xB returns the synchronized `spi_miso` level on bit 7 and 0 on bits 6..0.
- R5: When the serial path is enabled, reads of offsets other than 0xA/0xB return `core_rdata` unchanged.
- R6: `xcvr_oe` is 1 during every device access (`dev_sel_n` low) and 0 when idle. `xcvr_to_bus` is 1 only during read accesses. Outside read accesses `bus_rdata` is 0x00.
- R7: With chip-select granted, eight read accesses to 0xA (bit 0) or 0xB (bit 1), sent MSB first, deliver that byte to a slave that shifts on strobe rising edges. The slave's reply bits appear on D7 of those reads in order, MSB first.
- R8: A control write of the release value 0x5A clears `cs_drive_low`. A control write of any other value leaves it unchanged.
- R9: When `cs_sense` is low (external jumper) while `cs_drive_low` is 0, reads of 0xA/0xB return the reply bit as in R4.
- R10: Synchronous reset releases a granted chip-select: `cs_drive_low` is 0 on the cycle after reset is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel_n | input | 1 | Active-low device-region strobe (also the SPI clock on the board) |
| ctl_sel_n | input | 1 | Active-low strobe for the control location that takes the unlock/release value |
| bus_rd | input | 1 | 1 for a read cycle, 0 for a write cycle |
| bus_ofs | input | 4 | Offset within the device region (bit 0 is the serial data bit) |
| bus_wdata | input | 8 | Write data from the host |
| core_rdata | input | 8 | Normal disk-controller register value for the current offset |
| spi_miso | input | 1 | Serial reply pin of the configuration port |
| cs_sense | input | 1 | Level sensed on the chip-select pin |
| cs_drive_low | output | 1 | 1 drives the open-drain chip-select low, 0 leaves it high-impedance |
| bus_rdata | output | 8 | Read data toward the bus transceiver |
| xcvr_oe | output | 1 | Transceiver enable |
| xcvr_to_bus | output | 1 | Transceiver direction, 1 toward the host bus |

## Verification
The bench builds the bridge with its default parameters. These are two synchronizer stages, a 4-bit offset, 0xA5/0x5A as the grant and release values, and 0xA as the reply pair base. With these values, the synchronizer latency of three clock edges fits easily inside a strobe held low for tens of cycles. The reply mux can be reached from both reply offsets and from a neighbouring non-reply offset. A full 8-bit exchange with a modelled slave checks the received byte and the reply bits together. The jumper-forced chip-select path is exercised separately from the grant register.

// File: rtl/spibr_pkg.sv
package spibr_pkg;
  typedef enum logic [1:0] {
    CS_CMD_NONE    = 2'd0,
    CS_CMD_GRANT   = 2'd1,
    CS_CMD_RELEASE = 2'd2
  } cs_cmd_e;
endpackage

// File: rtl/spibr_sync.sv
module spibr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spibr_cs_ctrl.sv
module spibr_cs_ctrl
  import spibr_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] GRANT_VAL = 8'hA5,
  parameter logic [DATA_W-1:0] FREE_VAL  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [DATA_W-1:0] wdata,
  output logic              cs_drive_low
);
  cs_cmd_e cmd;

  always_comb begin
    cmd = CS_CMD_NONE;
    if (wr_evt) begin
      if (wdata == GRANT_VAL)     cmd = CS_CMD_GRANT;
      else if (wdata == FREE_VAL) cmd = CS_CMD_RELEASE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cs_drive_low <= 1'b0;
    else begin
      case (cmd)
        CS_CMD_GRANT:   cs_drive_low <= 1'b1;
        CS_CMD_RELEASE: cs_drive_low <= 1'b0;
        default:        cs_drive_low <= cs_drive_low;
      endcase
    end
  end

  // R8: without a control write the grant state never moves
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> $stable(cs_drive_low));

  // R10: reset always leaves chip-select released
  a_r10_reset_release: assert property (@(posedge clk)
    rst |=> !cs_drive_low);
endmodule

// File: rtl/spibr_read_path.sv
module spibr_read_path #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] REPLY_OFS = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_active,
  input  logic              acc_read,
  input  logic [ADDR_W-1:0] acc_ofs,
  input  logic              spi_path,
  input  logic              reply_bit,
  input  logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              xcvr_oe,
  output logic              xcvr_to_bus
);
  localparam logic [ADDR_W-1:0] PAIR_MASK = ~{{(ADDR_W-1){1'b0}}, 1'b1};

  logic reply_hit;
  assign reply_hit = ((acc_ofs ^ REPLY_OFS) & PAIR_MASK) == '0;

  always_ff @(posedge clk) begin
    if (rst || !acc_active) begin
      bus_rdata   <= '0;
      xcvr_oe     <= 1'b0;
      xcvr_to_bus <= 1'b0;
    end else begin
      xcvr_oe     <= 1'b1;
      xcvr_to_bus <= acc_read;
      if (!acc_read)                 bus_rdata <= '0;
      else if (reply_hit && spi_path) bus_rdata <= {reply_bit, {(DATA_W-1){1'b0}}};
      else                           bus_rdata <= core_rdata;
    end
  end

  // R4: a serial-mode reply read carries nothing below the top bit
  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (acc_active && acc_read && reply_hit && spi_path) |=> (bus_rdata[DATA_W-2:0] == '0));

  // R2: with the serial path off, reads pass the register value through
  a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
    (acc_active && acc_read && !spi_path) |=> (bus_rdata == $past(core_rdata)));
endmodule

// File: rtl/spi_bitbang_bridge.sv
module spi_bitbang_bridge #(
  parameter int               DATA_W      = 8,
  parameter int               ADDR_W      = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [7:0]       GRANT_VAL   = 8'hA5,
  parameter logic [7:0]       FREE_VAL    = 8'h5A,
  parameter logic [3:0]       REPLY_OFS   = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_sel_n,
  input  logic              ctl_sel_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_ofs,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] core_rdata,
  input  logic              spi_miso,
  input  logic              cs_sense,
  output logic              cs_drive_low,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              xcvr_oe,
  output logic              xcvr_to_bus
);
  logic dev_sel_s, ctl_sel_s, miso_s, cs_sense_s;
  logic ctl_sel_prev, ctl_fall, wr_evt, spi_path;

  spibr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dev (
    .clk(clk), .rst(rst), .d(dev_sel_n), .q(dev_sel_s));
  spibr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_sel_n), .q(ctl_sel_s));
  spibr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_miso (
    .clk(clk), .rst(rst), .d(spi_miso), .q(miso_s));
  spibr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sense (
    .clk(clk), .rst(rst), .d(cs_sense), .q(cs_sense_s));

  always_ff @(posedge clk) begin
    if (rst) ctl_sel_prev <= 1'b1;
    else     ctl_sel_prev <= ctl_sel_s;
  end

  assign ctl_fall = ctl_sel_prev && !ctl_sel_s;
  assign wr_evt   = ctl_fall && !bus_rd;

  spibr_cs_ctrl #(
    .DATA_W(DATA_W), .GRANT_VAL(GRANT_VAL[DATA_W-1:0]), .FREE_VAL(FREE_VAL[DATA_W-1:0])
  ) u_cs (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wdata(bus_wdata), .cs_drive_low(cs_drive_low));

  assign spi_path = cs_drive_low || !cs_sense_s;

  spibr_read_path #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REPLY_OFS(REPLY_OFS[ADDR_W-1:0])
  ) u_rd (
    .clk(clk), .rst(rst), .acc_active(!dev_sel_s), .acc_read(bus_rd), .acc_ofs(bus_ofs),
    .spi_path(spi_path), .reply_bit(miso_s), .core_rdata(core_rdata),
    .bus_rdata(bus_rdata), .xcvr_oe(xcvr_oe), .xcvr_to_bus(xcvr_to_bus));

  // R6: the transceiver is quiet one cycle after the strobe is seen idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    dev_sel_s |=> (!xcvr_oe && !xcvr_to_bus && bus_rdata == '0));
endmodule

// File: tb/spi_bitbang_bridge_tb_top.sv
module spi_bitbang_bridge_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_sel_n = 1'b1, ctl_sel_n = 1'b1, bus_rd = 1'b1;
  logic [3:0] bus_ofs = 4'h0;
  logic [7:0] bus_wdata = 8'h00, core_rdata = 8'h3C;
  logic jumper = 1'b0;
  logic cs_drive_low, xcvr_oe, xcvr_to_bus, cs_sense, spi_miso;
  logic [7:0] bus_rdata;

  logic [7:0] slv_rx = 8'h00, slv_tx = 8'h00;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed { logic oe; logic tb; logic [7:0] d; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  event  smp_ev;

  always #4 clk = ~clk;

  assign cs_sense = !(cs_drive_low || jumper);
  assign spi_miso = slv_tx[7];

  // SPI slave model: shifts on strobe rising edge while chip-select pin is low
  always @(posedge dev_sel_n) begin
    if (!cs_sense) begin
      slv_rx <= {slv_rx[6:0], bus_ofs[0]};
      slv_tx <= {slv_tx[6:0], 1'b0};
    end
  end

  spi_bitbang_bridge dut_i (
    .clk(clk), .rst(rst), .dev_sel_n(dev_sel_n), .ctl_sel_n(ctl_sel_n), .bus_rd(bus_rd),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .core_rdata(core_rdata), .spi_miso(spi_miso),
    .cs_sense(cs_sense), .cs_drive_low(cs_drive_low), .bus_rdata(bus_rdata),
    .xcvr_oe(xcvr_oe), .xcvr_to_bus(xcvr_to_bus));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() != 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {22'd0, xcvr_oe, xcvr_to_bus, bus_rdata}, {22'd0, e.oe, e.tb, e.d});
      end
    end
  end

  task automatic access(input logic rd, input logic [3:0] ofs, input exp_t e, input string tag);
    @(negedge clk);
    bus_rd = rd; bus_ofs = ofs; dev_sel_n = 1'b0;
    repeat (10) @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    -> smp_ev;
    repeat (2) @(negedge clk);
    dev_sel_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({tag, " idle"}, {29'd0, xcvr_oe, xcvr_to_bus, |bus_rdata}, 32'd0);
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b0; bus_wdata = v; ctl_sel_n = 1'b0;
    repeat (6) @(negedge clk);
    ctl_sel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] tx_byte, reply;
    tx_byte = 8'h96; reply = 8'hC5;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset", {21'd0, cs_drive_low, xcvr_oe, xcvr_to_bus, bus_rdata}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {21'd0, cs_drive_low, xcvr_oe, xcvr_to_bus, bus_rdata}, 32'd0);

    // R2: serial path disabled, reply offsets pass through
    access(1'b1, 4'hA, '{1'b1, 1'b1, 8'h3C}, "R2 read 0xA disabled");
    core_rdata = 8'h7E;
    access(1'b1, 4'hB, '{1'b1, 1'b1, 8'h7E}, "R2 read 0xB disabled");
    // R6: write access direction and zero read data
    access(1'b0, 4'h5, '{1'b1, 1'b0, 8'h00}, "R6 write access");

    // R8: other values ignored; R3: grant
    ctl_write(8'h00);
    chk("R8 other value ignored", {31'd0, cs_drive_low}, 32'd0);
    ctl_write(8'hA5);
    chk("R3 grant", {31'd0, cs_drive_low}, 32'd1);
    ctl_write(8'h33);
    chk("R8 other value keeps grant", {31'd0, cs_drive_low}, 32'd1);

    // R7/R4: byte exchange with the slave model
    slv_rx = 8'h00; slv_tx = reply;
    for (int i = 7; i >= 0; i--) begin
      access(1'b1, tx_byte[i] ? 4'hB : 4'hA, '{1'b1, 1'b1, {reply[i], 7'b0}},
             $sformatf("R7 R4 reply bit %0d", i));
    end
    chk("R7 slave received byte", {24'd0, slv_rx}, {24'd0, tx_byte});

    // R5: non-reply offset while enabled
    core_rdata = 8'h81;
    access(1'b1, 4'h4, '{1'b1, 1'b1, 8'h81}, "R5 read 0x4 enabled");
    access(1'b1, 4'hC, '{1'b1, 1'b1, 8'h81}, "R5 read 0xC enabled");

    // R8: release
    ctl_write(8'h5A);
    chk("R8 release", {31'd0, cs_drive_low}, 32'd0);
    access(1'b1, 4'hA, '{1'b1, 1'b1, 8'h81}, "R2 read after release");

    // R9: jumper-forced chip-select
    slv_tx = 8'h80;
    jumper = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b1, 4'hB, '{1'b1, 1'b1, 8'h80}, "R9 jumper reply 1");
    access(1'b1, 4'hA, '{1'b1, 1'b1, 8'h00}, "R9 jumper reply 0");
    jumper = 1'b0;
    repeat (4) @(negedge clk);

    // R10: reset releases a granted chip-select
    ctl_write(8'hA5);
    chk("R10 granted before reset", {31'd0, cs_drive_low}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset release", {31'd0, cs_drive_low}, 32'd0);

    repeat (4) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule